// File: doc/BRIEF.md
# LCD Frame Fetch Controller

This block keeps a shift-register style LCD panel refreshed by acting as a bus master for one frame at a time. Software first sets up the transfer. It programs the word size, the frame base address, the visible width and height, the stride of the larger virtual image, and the horizontal and vertical pan offsets. It then writes the start register. The controller raises a bus request toward the CPU and waits for the grant. Once it holds the grant, it reads one 32-bit display word per accepted handshake. Each word feeds an output stage that drives the panel data bus and toggles the panel shift clock.

Words are read in row-major order from a window inside the virtual image. The pan offsets move that window, which gives hardware scrolling. After the last word of the frame, the request is dropped at once so the CPU gets the bus back, and a one-cycle interrupt pulse marks the end of the frame. If the grant is taken away in the middle of a frame, fetching pauses and later continues from the word where it stopped.

Top module: `lcd_fetch_ctrl`

## Requirements
- R1: After reset, bus_req, busy, irq, mem_rd_valid, pnl_clk and pnl_data are all 0.
- R2: A write to the start register (index 5) has no effect when the width field (size register index 2, bits 15:0) or the height field (bits 31:16) is zero. busy and bus_req stay 0.
- R3: In the cycle after an accepted start write, bus_req and busy are 1 and mem_rd_valid is 0. mem_rd_valid stays 0 until bus_gnt is seen.
- R4: mem_rd_valid is 1 only while bus_req and bus_gnt are both 1.
- R5: Each frame completes exactly width×height read handshakes (mem_rd_valid and mem_rd_ready both high at a clock edge), and no more.
- R6: Word x of line y is read at base + (y+pan_y)×stride + ((x+pan_x) << s). The pan register is index 3, with pan_x in bits 15:0 and pan_y in bits 31:16. Base is index 1 and stride is index 4. s comes from mode register index 0, bits 1:0: 0 gives s=0, 1 gives s=1, and 2 or 3 gives s=2. Words are read with x running fastest.
- R7: bus_req and busy fall in the cycle right after the final handshake of the frame.
- R8: irq is high for exactly one cycle: the cycle after the final handshake.
- R9: After each handshake, pnl_data carries bits 11:0 of the word read and pnl_clk changes level. In cycles with no handshake, both hold their values.
- R10: While bus_gnt is low in the middle of a frame, no read is issued. Fetching then resumes at the same word, so no word is skipped and none is read twice.
- R11: While mem_rd_valid is high and mem_rd_ready is low, mem_addr holds steady.
- R12: A start write made while busy is ignored. This includes a start write in the same cycle as the final handshake: after that frame, busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| bus_gnt | input | 1 | Bus grant from the CPU |
| mem_rd_ready | input | 1 | Memory accepts the read and returns data this cycle |
| mem_rd_data | input | 32 | Read data returned with mem_rd_ready |
| bus_req | output | 1 | Bus release request toward the CPU |
| busy | output | 1 | A frame is in progress |
| irq | output | 1 | End-of-frame pulse |
| mem_rd_valid | output | 1 | Read request valid |
| mem_addr | output | 32 | Read byte address |
| pnl_data | output | 12 | Panel data bus |
| pnl_clk | output | 1 | Panel shift clock, toggles once per word |

## Verification
The final read handshake of a frame and a new start write can fall on the same clock edge. The bench provokes this by raising the start write on the edge where the last word is accepted. The expected result is that the frame ends normally, with bus_req dropping and irq pulsing, and that no new request follows in the next two cycles. A second overlap is a grant withdrawal during a memory stall. The bench runs both the grant pattern and the ready pattern at once, and it judges the result by comparing every accepted address against an independently computed row-major sequence.

// File: rtl/lcd_fetch_pkg.sv
// Shared types and constants for the LCD frame fetch controller.
// Assumes a 32-bit register data path.
package lcd_fetch_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_REQ   = 2'd1,
        FS_FETCH = 2'd2
    } fetch_state_t;

    localparam logic [2:0] RG_MODE   = 3'd0;
    localparam logic [2:0] RG_BASE   = 3'd1;
    localparam logic [2:0] RG_SIZE   = 3'd2;
    localparam logic [2:0] RG_PAN    = 3'd3;
    localparam logic [2:0] RG_STRIDE = 3'd4;
    localparam logic [2:0] RG_START  = 3'd5;

    // Byte shift for one display word, chosen by the mode field.
    function automatic logic [1:0] word_shift(input logic [1:0] m);
        return (m == 2'd0) ? 2'd0 : (m == 2'd1) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/lcd_fetch_regs.sv
// Register file: holds the frame setup and decodes the start strobe.
// Assumes RW == 32 and CW <= 16 (size and pan fields sit in two 16-bit halves).
module lcd_fetch_regs
    import lcd_fetch_pkg::*;
#(
    parameter int RW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [1:0]    mode,
    output logic [RW-1:0] base,
    output logic [RW-1:0] stride,
    output logic [CW-1:0] width,
    output logic [CW-1:0] height,
    output logic [CW-1:0] pan_x,
    output logic [CW-1:0] pan_y,
    output logic          start_pulse
);
    localparam int HI = RW / 2;

    // Capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= '0;
            base   <= '0;
            stride <= '0;
            width  <= '0;
            height <= '0;
            pan_x  <= '0;
            pan_y  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RG_MODE:   mode   <= reg_wdata[1:0];
                RG_BASE:   base   <= reg_wdata;
                RG_STRIDE: stride <= reg_wdata;
                RG_SIZE: begin
                    width  <= reg_wdata[CW-1:0];
                    height <= reg_wdata[HI+CW-1:HI];
                end
                RG_PAN: begin
                    pan_x <= reg_wdata[CW-1:0];
                    pan_y <= reg_wdata[HI+CW-1:HI];
                end
                default: ;
            endcase
        end
    end

    // Start strobe, valid for one cycle with the write.
    always_comb start_pulse = reg_wr && (reg_addr == RG_START);

endmodule

// File: rtl/lcd_fetch_seq.sv
// Frame sequencer: bus request handshake, read issue and x/y word counters.
// Assumes memory data returns in the same cycle as mem_rd_ready.
module lcd_fetch_seq
    import lcd_fetch_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_pulse,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          bus_gnt,
    input  logic          mem_rd_ready,
    output logic          bus_req,
    output logic          rd_valid,
    output logic          beat,
    output logic          irq,
    output logic [CW-1:0] x_cnt,
    output logic [CW-1:0] y_cnt
);
    fetch_state_t state_q;
    logic         last_x, last_y, size_ok;

    // Decode end-of-line, end-of-frame and the handshake.
    always_comb begin
        last_x   = (x_cnt == width - CW'(1));
        last_y   = (y_cnt == height - CW'(1));
        size_ok  = (width != '0) && (height != '0);
        bus_req  = (state_q != FS_IDLE);
        rd_valid = (state_q == FS_FETCH) && bus_gnt;
        beat     = rd_valid && mem_rd_ready;
    end

    // State machine and row-major word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            x_cnt   <= '0;
            y_cnt   <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= beat && last_x && last_y;
            case (state_q)
                FS_IDLE: if (start_pulse && size_ok) begin
                    state_q <= FS_REQ;
                    x_cnt   <= '0;
                    y_cnt   <= '0;
                end
                FS_REQ: if (bus_gnt) state_q <= FS_FETCH;
                FS_FETCH: if (beat) begin
                    if (last_x) begin
                        x_cnt <= '0;
                        if (last_y) state_q <= FS_IDLE;
                        else        y_cnt   <= y_cnt + CW'(1);
                    end else begin
                        x_cnt <= x_cnt + CW'(1);
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_fetch_addr.sv
// Address generator: base + panned row times stride + panned column times word size.
// Assumes AW > CW; wraps modulo 2^AW.
module lcd_fetch_addr
    import lcd_fetch_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [CW-1:0] pan_x,
    input  logic [CW-1:0] pan_y,
    input  logic [CW-1:0] x_cnt,
    input  logic [CW-1:0] y_cnt,
    output logic [AW-1:0] addr
);
    logic [CW:0]   row_w, col_w;
    logic [AW-1:0] row_off, col_off;

    // Combine the counters with the pan offsets into a byte address.
    always_comb begin
        row_w   = {1'b0, y_cnt} + {1'b0, pan_y};
        col_w   = {1'b0, x_cnt} + {1'b0, pan_x};
        row_off = AW'(row_w) * stride;
        col_off = AW'(col_w) << word_shift(mode);
        addr    = base + row_off + col_off;
    end

endmodule

// File: rtl/lcd_fetch_out.sv
// Output stage: registers panel data and toggles the shift clock per word.
// Assumes PW <= DW; the low PW bits of each word form the panel data.
module lcd_fetch_out #(
    parameter int DW = 32,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic [DW-1:0] word,
    output logic [PW-1:0] pnl_data,
    output logic          pnl_clk
);
    // Load one word onto the panel bus on each read handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnl_data <= '0;
            pnl_clk  <= 1'b0;
        end else if (beat) begin
            pnl_data <= word[PW-1:0];
            pnl_clk  <= ~pnl_clk;
        end
    end

endmodule

// File: rtl/lcd_fetch_ctrl.sv
// Top of the LCD frame fetch controller: registers, sequencer, address
// generator and panel output stage. Assumes a 32-bit register and memory path.
module lcd_fetch_ctrl #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int PW = 12,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          bus_gnt,
    input  logic          mem_rd_ready,
    input  logic [DW-1:0] mem_rd_data,
    output logic          bus_req,
    output logic          busy,
    output logic          irq,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] pnl_data,
    output logic          pnl_clk
);
    logic [1:0]    mode;
    logic [31:0]   base, stride;
    logic [CW-1:0] width, height, pan_x, pan_y, x_cnt, y_cnt;
    logic          start_pulse, beat, req_int;

    lcd_fetch_regs #(.RW(32), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mode(mode), .base(base), .stride(stride),
        .width(width), .height(height), .pan_x(pan_x), .pan_y(pan_y),
        .start_pulse(start_pulse)
    );

    lcd_fetch_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .width(width),
        .height(height), .bus_gnt(bus_gnt), .mem_rd_ready(mem_rd_ready),
        .bus_req(req_int), .rd_valid(mem_rd_valid), .beat(beat), .irq(irq),
        .x_cnt(x_cnt), .y_cnt(y_cnt)
    );

    lcd_fetch_addr #(.AW(AW), .CW(CW)) u_addr (
        .mode(mode), .base(AW'(base)), .stride(AW'(stride)), .pan_x(pan_x),
        .pan_y(pan_y), .x_cnt(x_cnt), .y_cnt(y_cnt), .addr(mem_addr)
    );

    lcd_fetch_out #(.DW(DW), .PW(PW)) u_out (
        .clk(clk), .rst_n(rst_n), .beat(beat), .word(mem_rd_data),
        .pnl_data(pnl_data), .pnl_clk(pnl_clk)
    );

    // Busy and the bus request share the frame-in-progress condition.
    always_comb begin
        bus_req = req_int;
        busy    = req_int;
    end

endmodule

// File: rtl/lcd_fetch_chk.sv
// Protocol checker for lcd_fetch_ctrl, attached with bind.
module lcd_fetch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          busy,
    input logic          irq,
    input logic          mem_rd_valid,
    input logic          mem_rd_ready,
    input logic [AW-1:0] mem_addr,
    input logic          pnl_clk
);
    // R3
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (busy && !mem_rd_valid));

    // R4
    valid_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (bus_req && bus_gnt));

    // R8
    irq_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(bus_req) && !bus_req));

    // R9
    pnl_clk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_clk != $past(pnl_clk)) == $past(mem_rd_valid && mem_rd_ready));

    // R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_req && !bus_gnt) && bus_req) |-> $stable(mem_addr));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_rd_valid && !mem_rd_ready) && mem_rd_valid) |-> $stable(mem_addr));

endmodule

bind lcd_fetch_ctrl lcd_fetch_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .busy(busy), .irq(irq), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_addr(mem_addr), .pnl_clk(pnl_clk)
);

// File: tb/lcd_fetch_ctrl_test.sv
// Directed bench for lcd_fetch_ctrl: one task per scenario.
module lcd_fetch_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        bus_gnt = 1'b0;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_data;
    logic        bus_req, busy, irq, mem_rd_valid, pnl_clk;
    logic [31:0] mem_addr;
    logic [11:0] pnl_data;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    // Memory model: data is a fixed function of the address.
    always_comb mem_rd_data = {mem_addr[19:0], mem_addr[11:0] ^ 12'h5A3};

    lcd_fetch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bus_gnt(bus_gnt), .mem_rd_ready(mem_rd_ready),
        .mem_rd_data(mem_rd_data), .bus_req(bus_req), .busy(busy), .irq(irq),
        .mem_rd_valid(mem_rd_valid), .mem_addr(mem_addr), .pnl_data(pnl_data),
        .pnl_clk(pnl_clk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk(!bus_req && !busy && !irq, "R1", "req/busy/irq", {bus_req, busy, irq}, 0);
        chk(!mem_rd_valid && !pnl_clk && pnl_data == 0, "R1", "valid/pnl",
            {mem_rd_valid, pnl_clk, pnl_data}, 0);
    endtask

    // R2: start with an empty size is ignored
    task automatic t_zero_size(input logic [31:0] size);
        wr(3'd2, size);
        wr(3'd5, 32'h1);
        chk(!busy && !bus_req, "R2", "busy after start", busy, 0);
        @(negedge clk);
        chk(!busy && !bus_req, "R2", "busy later", busy, 0);
    endtask

    // Full frame with grant/ready patterns; optional start in the last-beat cycle.
    task automatic t_frame(input int w, input int h, input int px, input int py,
                           input logic [31:0] stride, input logic [31:0] base,
                           input logic [1:0] mode, input bit gpat, input bit rpat,
                           input bit collide);
        int sh = (mode == 0) ? 0 : (mode == 1) ? 1 : 2;
        int total = w * h;
        int idx = 0;
        int cyc = 0;
        bit pend = 0;
        logic [11:0] pend_d = '0;
        logic last_pclk;
        bit prev_stall = 0;
        logic [31:0] prev_addr = '0;
        wr(3'd0, {30'd0, mode});
        wr(3'd1, base);
        wr(3'd4, stride);
        wr(3'd2, {h[15:0], w[15:0]});
        wr(3'd3, {py[15:0], px[15:0]});
        bus_gnt = 1'b0; mem_rd_ready = 1'b1;
        wr(3'd5, 32'h1);
        // R3: request up, no read before grant
        chk(bus_req && busy, "R3", "req after start", {bus_req, busy}, 3);
        for (int i = 0; i < 3; i++) begin
            chk(!mem_rd_valid, "R3", "valid without grant", mem_rd_valid, 0);
            @(negedge clk);
        end
        last_pclk = pnl_clk;
        while (idx < total && cyc < 5000) begin
            if (cyc > 0) @(negedge clk);
            // R9: panel output after the previous cycle
            if (pend) begin
                chk(pnl_data == pend_d, "R9", "pnl_data", pnl_data, pend_d);
                chk(pnl_clk == ~last_pclk, "R9", "pnl_clk toggle", pnl_clk, ~last_pclk);
            end else begin
                chk(pnl_clk == last_pclk, "R9", "pnl_clk hold", pnl_clk, last_pclk);
            end
            last_pclk = pnl_clk;
            pend = 0;
            bus_gnt      = gpat ? ((cyc % 5) != 3) : 1'b1;
            mem_rd_ready = rpat ? ((cyc % 3) != 1) : 1'b1;
            #1;
            // R4 / R10: no read without grant
            if (!bus_gnt) chk(!mem_rd_valid, "R10", "valid while ungranted", mem_rd_valid, 0);
            // R11: stalled address holds
            if (prev_stall && mem_rd_valid)
                chk(mem_addr == prev_addr, "R11", "addr hold", mem_addr, prev_addr);
            if (mem_rd_valid && mem_rd_ready) begin
                logic [31:0] ex;
                int x = idx % w;
                int y = idx / w;
                ex = base + 32'(y + py) * stride + (32'(x + px) << sh);
                // R6: row-major panned address
                chk(mem_addr == ex, "R6", "read address", mem_addr, ex);
                pend = 1; pend_d = ex[11:0] ^ 12'h5A3;
                idx++;
                if (idx == total && collide) begin
                    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h1;
                end
            end
            prev_stall = mem_rd_valid && !mem_rd_ready;
            prev_addr = mem_addr;
            cyc++;
        end
        @(negedge clk);
        reg_wr = 1'b0;
        bus_gnt = 1'b1; mem_rd_ready = 1'b1;
        chk(idx == total, "R5", "beat count", idx, total);
        chk(pnl_data == pend_d, "R9", "final pnl_data", pnl_data, pend_d);
        // R7 / R8: request dropped, interrupt pulse
        chk(!bus_req && !busy, "R7", "req after last", {bus_req, busy}, 0);
        chk(irq, "R8", "irq pulse", irq, 1);
        #1;
        chk(!mem_rd_valid, "R5", "no extra read", mem_rd_valid, 0);
        @(negedge clk);
        chk(!irq, "R8", "irq one cycle", irq, 0);
        if (collide) chk(!busy && !bus_req, "R12", "start in last cycle", busy, 0);
        bus_gnt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero_size({16'd4, 16'd0});
        t_zero_size({16'd0, 16'd4});
        t_frame(4, 3, 0, 0, 32'd64, 32'h1000, 2'd2, 0, 0, 0);
        t_frame(5, 2, 3, 7, 32'd200, 32'h8000, 2'd1, 1, 0, 0);
        t_frame(7, 2, 1, 2, 32'd33, 32'h40, 2'd0, 1, 1, 0);
        t_frame(3, 2, 2, 1, 32'd96, 32'h200, 2'd3, 0, 1, 0);
        t_frame(2, 2, 0, 0, 32'd16, 32'h0, 2'd2, 0, 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule